// File: doc/BRIEF.md
# Synchronous rectifier anticipation timer

This block sequences the two synchronous-rectifier gate enables on the secondary side of a forward converter. A fast tick clock runs it. It watches a digitized synchronizing clock `ckIn`. Level changes on `ckIn` that last fewer than `MIN_PULSE` ticks are discarded. Each qualified high phase and low phase is timed with a tick counter, and the stored lengths of the previous cycle predict when the next edge will arrive.

The forward gate (`gateFwd`) conducts during the high phase of the synchronizing clock. The freewheel gate (`gateFree`) conducts during the low phase. Each gate switches on a fixed delay after its starting edge. It switches off a set number of ticks before the edge it predicts, which leaves dead time between the two enables. The freewheel gate can also be cut short by a current-reversal flag, but only after it has conducted for a minimum time.

In the standard variant, both gates are suppressed while the measured duty cycle is low, with hysteresis on recovery. A mode pin selects a low-duty variant that never suppresses the gates. The gates are meant to feed external drivers. The undervoltage flag comes from an external supply monitor.

Top module: `srAntTimer`

## Requirements
- R1: While `rstN` is low, and in the cycle after any cycle with `uvOk` low, both gates are low. Dropping `uvOk` also discards all phase measurements.
- R2: Neither gate rises until three qualified edges of `ckIn` have occurred since reset or since `uvOk` last returned high. With three edges, both a high phase and a low phase have been measured.
- R3: `gateFwd` and `gateFree` are never high in the same cycle.
- R4: A level on `ckIn` that differs from the filtered level for fewer than `MIN_PULSE` (default 3) consecutive tick samples has no effect on either gate. The filtered level follows on the `MIN_PULSE`-th consecutive differing sample.
- R5: Let H be the previous high-phase length in ticks. `gateFwd` rises `MIN_PULSE+TON1` ticks after the first tick that samples `ckIn` high, and stays high for H−ANT1−TON1 ticks. With the defaults TON1=2 and ANT1=1, this gives H−3 ticks.
- R6: Let L be the previous low-phase length in ticks. `gateFree` rises `MIN_PULSE+TON2` ticks after the first tick that samples `ckIn` low, and stays high for L−A−TON2 ticks. A is chosen by `antSel`: 0 gives ANT2_STEP, 1 gives 2·ANT2_STEP, and 2 or 3 give 3·ANT2_STEP. With the defaults TON2=1 and ANT2_STEP=1, this is L−2, L−3 or L−4 ticks.
- R7: A gate does not turn on in a phase whose predicted length is not greater than its anticipation plus its turn-on delay.
- R8: While `inhibit` is 1, `gateFree` turns off once it has been high for `MIN_ON2` (default 4) ticks. It stays off for the rest of that low phase, and it still completes `MIN_ON2` ticks even if `inhibit` was already 1 when it rose.
- R9: With `lowDutyMode`=0, both gates are suppressed when 100·H < 13·(H+L). They are released only when 100·H > 16·(H+L). Between these limits the previous state holds.
- R10: With `lowDutyMode`=1, the duty-cycle suppression never applies.
- R11: If a phase ends before its predicted length, the gate of that phase is low from the first cycle after the filtered edge. A gate that started `TON` ticks after its phase began therefore has a width of the actual phase length minus `TON`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ckIn | input | 1 | Digitized synchronizing clock |
| antSel | input | 2 | Freewheel anticipation select (0, 1, 2/3) |
| inhibit | input | 1 | 1 = current reversal in the freewheel device |
| lowDutyMode | input | 1 | 1 = low-duty variant, shutdown disabled |
| uvOk | input | 1 | Supply above lockout threshold |
| gateFwd | output | 1 | Forward rectifier gate enable |
| gateFree | output | 1 | Freewheel rectifier gate enable |

## Verification
The assertions check four things on every cycle: the two gates never overlap, no gate is high before the three-edge measurement is complete, the gates fall after an undervoltage cycle, and the filtered clock only moves to a level that `ckIn` actually held. They also check that the duty shutdown can only engage while the standard variant is selected. Other behaviours only show up across whole cycles of `ckIn` in the bench's scenarios: the exact gate widths for each anticipation select, the skipped pulses for short phases, the glitch rejection, the minimum conduction under inhibit, the shutdown hysteresis band and the truncation on an early edge. The bench's tick-accurate reference model checks these on every clock.

// File: rtl/srAntPkg.sv
package srAntPkg;
  // strobes issued by the control to the measurement datapath
  typedef struct packed {
    logic capHigh;   // store the high phase that just ended
    logic capLow;    // store the low phase that just ended
  } measStrobeT;
endpackage

// File: rtl/srAntDatapath.sv
module srAntDatapath #(
  parameter int CNT_W     = 12,
  parameter int MIN_PULSE = 3,
  parameter int SHUT_PCT  = 13,
  parameter int RUN_PCT   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ckIn,
  input  srAntPkg::measStrobeT   stb,
  output logic                   riseStb,
  output logic                   fallStb,
  output logic [CNT_W-1:0]       elapsedNext,
  output logic [CNT_W-1:0]       highLen,
  output logic [CNT_W-1:0]       lowLen,
  output logic                   dutyTooLow,
  output logic                   dutyRecovered
);
  localparam int PROD_W = CNT_W + 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ckFilt;
  logic             ckFiltQ;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lenSample;

  // glitch rejection: follow ckIn only after MIN_PULSE differing samples
  generate
    if (MIN_PULSE <= 1) begin : g_noFilter
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ckFilt <= 1'b0;
        else       ckFilt <= ckIn;
      end
    end else begin : g_filter
      localparam int FLT_W = $clog2(MIN_PULSE + 1);
      logic [FLT_W-1:0] fltCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          fltCnt <= '0;
          ckFilt <= 1'b0;
        end else if (ckIn != ckFilt) begin
          if (fltCnt == FLT_W'(MIN_PULSE - 1)) begin
            ckFilt <= ckIn;
            fltCnt <= '0;
          end else begin
            fltCnt <= fltCnt + 1'b1;
          end
        end else begin
          fltCnt <= '0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ckFiltQ <= 1'b0;
    else       ckFiltQ <= ckFilt;
  end

  assign riseStb = ckFilt & ~ckFiltQ;
  assign fallStb = ~ckFilt & ckFiltQ;

  // ticks elapsed since the last filtered edge (0 in the edge cycle)
  always_comb begin
    if (riseStb || fallStb)     elapsedNext = '0;
    else if (phaseCnt == CNT_MAX) elapsedNext = phaseCnt;
    else                        elapsedNext = phaseCnt + 1'b1;
    lenSample = (phaseCnt == CNT_MAX) ? phaseCnt : phaseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      highLen  <= '0;
      lowLen   <= '0;
    end else begin
      phaseCnt <= elapsedNext;
      if (stb.capHigh) highLen <= lenSample;
      if (stb.capLow)  lowLen  <= lenSample;
    end
  end

  // duty comparisons by scaled products, no divider
  logic [PROD_W-1:0] hiScaled;
  logic [PROD_W-1:0] sumLen;
  always_comb begin
    hiScaled      = PROD_W'(highLen) * PROD_W'(100);
    sumLen        = PROD_W'(highLen) + PROD_W'(lowLen);
    dutyTooLow    = hiScaled < (sumLen * PROD_W'(SHUT_PCT));
    dutyRecovered = hiScaled > (sumLen * PROD_W'(RUN_PCT));
  end

  // R4
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseStb, fallStb}));

  // R4
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ckFilt != $past(ckFilt)) |-> ($past(ckIn) == ckFilt));
endmodule

// File: rtl/srAntControl.sv
module srAntControl #(
  parameter int CNT_W     = 12,
  parameter int TON1      = 2,
  parameter int TON2      = 1,
  parameter int ANT1      = 1,
  parameter int ANT2_STEP = 1,
  parameter int MIN_ON2   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 uvOk,
  input  logic                 inhibit,
  input  logic                 lowDutyMode,
  input  logic [1:0]           antSel,
  input  logic                 riseStb,
  input  logic                 fallStb,
  input  logic [CNT_W-1:0]     elapsedNext,
  input  logic [CNT_W-1:0]     highLen,
  input  logic [CNT_W-1:0]     lowLen,
  input  logic                 dutyTooLow,
  input  logic                 dutyRecovered,
  output srAntPkg::measStrobeT stb,
  output logic                 gate1,
  output logic                 gate2
);
  localparam int ON_W = $clog2(MIN_ON2 + 1);
  localparam logic [CNT_W-1:0] LEAD1 = CNT_W'(ANT1 + TON1);

  function automatic logic [CNT_W-1:0] ant2Ticks(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(ANT2_STEP);
      2'd1:    return CNT_W'(2 * ANT2_STEP);
      default: return CNT_W'(3 * ANT2_STEP);
    endcase
  endfunction

  logic [1:0]       edgeCnt;
  logic             evalPend;
  logic             shut;
  logic             arm1, arm1Next;
  logic             arm2, arm2Next;
  logic             kill2, kill2Next;
  logic [ON_W-1:0]  on2Cnt;
  logic [CNT_W-1:0] ant2Q, ant2Cur;
  logic [CNT_W-1:0] stop1, stop2;
  logic             gate1Next, gate2Next;
  logic             measured;

  assign measured = (edgeCnt >= 2'd2);

  always_comb begin
    stb.capLow  = riseStb & uvOk;
    stb.capHigh = fallStb & uvOk;

    ant2Cur = fallStb ? ant2Ticks(antSel) : ant2Q;
    stop1   = highLen - CNT_W'(ANT1);
    stop2   = lowLen - ant2Cur;

    arm1Next = arm1;
    if (!uvOk)        arm1Next = 1'b0;
    else if (riseStb) arm1Next = measured && !shut && (highLen > LEAD1);
    else if (fallStb) arm1Next = 1'b0;

    arm2Next = arm2;
    if (!uvOk)        arm2Next = 1'b0;
    else if (fallStb) arm2Next = measured && !shut && (lowLen > ant2Cur + CNT_W'(TON2));
    else if (riseStb) arm2Next = 1'b0;

    if (!uvOk || fallStb) kill2Next = 1'b0;
    else kill2Next = kill2 | (gate2 && (on2Cnt >= ON_W'(MIN_ON2)) && inhibit);

    gate1Next = uvOk && !shut && arm1Next &&
                (elapsedNext >= CNT_W'(TON1)) && (elapsedNext < stop1);
    gate2Next = uvOk && !shut && arm2Next && !kill2Next &&
                (elapsedNext >= CNT_W'(TON2)) && (elapsedNext < stop2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt  <= '0;
      evalPend <= 1'b0;
      shut     <= 1'b0;
      arm1     <= 1'b0;
      arm2     <= 1'b0;
      kill2    <= 1'b0;
      on2Cnt   <= '0;
      ant2Q    <= '0;
      gate1    <= 1'b0;
      gate2    <= 1'b0;
    end else begin
      if (!uvOk)                                  edgeCnt <= '0;
      else if ((riseStb || fallStb) && edgeCnt != 2'd3) edgeCnt <= edgeCnt + 1'b1;

      evalPend <= (riseStb || fallStb) && uvOk;

      if (!uvOk || lowDutyMode)               shut <= 1'b0;
      else if (evalPend && edgeCnt == 2'd3)   shut <= shut ? !dutyRecovered : dutyTooLow;

      if (fallStb) ant2Q <= ant2Cur;
      arm1  <= arm1Next;
      arm2  <= arm2Next;
      kill2 <= kill2Next;
      gate1 <= gate1Next;
      gate2 <= gate2Next;
      if (!gate2Next)                      on2Cnt <= '0;
      else if (on2Cnt != ON_W'(MIN_ON2))   on2Cnt <= on2Cnt + 1'b1;
    end
  end

  // R3
  gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gate1 && gate2));

  // R1
  uv_gates_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !uvOk |=> (!gate1 && !gate2));

  // R2
  gate_after_measure_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gate1 || gate2) |-> (edgeCnt == 2'd3));

  // R10
  shut_standard_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shut) |-> !$past(lowDutyMode));
endmodule

// File: rtl/srAntTimer.sv
module srAntTimer #(
  parameter int CNT_W     = 12,
  parameter int MIN_PULSE = 3,
  parameter int TON1      = 2,
  parameter int TON2      = 1,
  parameter int ANT1      = 1,
  parameter int ANT2_STEP = 1,
  parameter int MIN_ON2   = 4,
  parameter int SHUT_PCT  = 13,
  parameter int RUN_PCT   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ckIn,
  input  logic [1:0] antSel,
  input  logic       inhibit,
  input  logic       lowDutyMode,
  input  logic       uvOk,
  output logic       gateFwd,
  output logic       gateFree
);
  srAntPkg::measStrobeT measStb;
  logic             riseStb, fallStb;
  logic [CNT_W-1:0] elapsedNext, highLen, lowLen;
  logic             dutyTooLow, dutyRecovered;

  srAntDatapath #(
    .CNT_W(CNT_W), .MIN_PULSE(MIN_PULSE), .SHUT_PCT(SHUT_PCT), .RUN_PCT(RUN_PCT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ckIn(ckIn), .stb(measStb),
    .riseStb(riseStb), .fallStb(fallStb), .elapsedNext(elapsedNext),
    .highLen(highLen), .lowLen(lowLen),
    .dutyTooLow(dutyTooLow), .dutyRecovered(dutyRecovered)
  );

  srAntControl #(
    .CNT_W(CNT_W), .TON1(TON1), .TON2(TON2), .ANT1(ANT1),
    .ANT2_STEP(ANT2_STEP), .MIN_ON2(MIN_ON2)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .uvOk(uvOk), .inhibit(inhibit),
    .lowDutyMode(lowDutyMode), .antSel(antSel),
    .riseStb(riseStb), .fallStb(fallStb), .elapsedNext(elapsedNext),
    .highLen(highLen), .lowLen(lowLen),
    .dutyTooLow(dutyTooLow), .dutyRecovered(dutyRecovered),
    .stb(measStb), .gate1(gateFwd), .gate2(gateFree)
  );
endmodule

// File: tb/srAntTimer_tb_top.sv
module srAntTimer_tb_top;
  localparam int MIN_PULSE = 3;
  localparam int TON1 = 2, TON2 = 1, ANT1 = 1, ANT2_STEP = 1, MIN_ON2 = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ck = 1'b0, inh = 1'b0, lowd = 1'b0, uv = 1'b1;
  logic [1:0] sel = 2'd0;
  logic gateFwd, gateFree;

  int nChk = 0, nFail = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  srAntTimer dut_i (
    .clk(clk), .rstN(rstN), .ckIn(ck), .antSel(sel), .inhibit(inh),
    .lowDutyMode(lowd), .uvOk(uv), .gateFwd(gateFwd), .gateFree(gateFree)
  );

  // ---------------- behavioural reference model ----------------
  longint tick, lastEdge;
  int fLvl, sameRun, pendEdge, edgesSeen, hiLen, loLen, evalNext, sup;
  int fwdArmed, freeArmed, freeCut, freeOn, antNow, expFwd, expFree;

  always @(posedge clk) begin
    if (!rstN) begin
      tick = 0; lastEdge = 0; fLvl = 0; sameRun = 0; pendEdge = 0;
      edgesSeen = 0; hiLen = 0; loLen = 0; evalNext = 0; sup = 0;
      fwdArmed = 0; freeArmed = 0; freeCut = 0; freeOn = 0; antNow = 0;
      expFwd = 0; expFree = 0;
    end else begin
      int edgeNow, prevSup, prevEdges, prevFree, prevOn, k;
      edgeNow = pendEdge; prevSup = sup; prevEdges = edgesSeen;
      prevFree = expFree; prevOn = freeOn;
      tick++;
      pendEdge = 0;
      if (int'(ck) != fLvl) begin
        sameRun++;
        if (sameRun == MIN_PULSE) begin
          fLvl = int'(ck); sameRun = 0; pendEdge = ck ? 1 : 2;
        end
      end else sameRun = 0;
      if (edgeNow != 0) begin
        if (uv) begin
          if (edgeNow == 1) loLen = int'(tick - lastEdge);
          else              hiLen = int'(tick - lastEdge);
        end
        lastEdge = tick;
      end
      k = int'(tick - lastEdge);
      if (!uv || lowd) sup = 0;
      else if (evalNext != 0 && prevEdges == 3)
        sup = sup ? int'(!(100 * hiLen > 16 * (hiLen + loLen)))
                  : int'(100 * hiLen < 13 * (hiLen + loLen));
      evalNext = (edgeNow != 0 && uv) ? 1 : 0;
      if (!uv) edgesSeen = 0;
      else if (edgeNow != 0 && edgesSeen < 3) edgesSeen++;
      if (!uv) fwdArmed = 0;
      else if (edgeNow == 1) fwdArmed = int'(prevEdges >= 2 && prevSup == 0 && hiLen > ANT1 + TON1);
      else if (edgeNow == 2) fwdArmed = 0;
      if (edgeNow == 2) antNow = (sel == 0) ? ANT2_STEP : (sel == 1) ? 2 * ANT2_STEP : 3 * ANT2_STEP;
      if (!uv) freeArmed = 0;
      else if (edgeNow == 2) freeArmed = int'(prevEdges >= 2 && prevSup == 0 && loLen > antNow + TON2);
      else if (edgeNow == 1) freeArmed = 0;
      if (!uv || edgeNow == 2) freeCut = 0;
      else if (prevFree != 0 && prevOn >= MIN_ON2 && inh) freeCut = 1;
      expFwd  = int'(uv && prevSup == 0 && fwdArmed != 0 && k >= TON1 && k < hiLen - ANT1);
      expFree = int'(uv && prevSup == 0 && freeArmed != 0 && freeCut == 0 &&
                     k >= TON2 && k < loLen - antNow);
      freeOn = expFree ? ((prevOn < MIN_ON2) ? prevOn + 1 : prevOn) : 0;
    end
  end

  // ---------------- checking ----------------
  int fwdRun = 0, freeRun = 0, lastFwdW = 0, lastFreeW = 0, fwdRises = 0, freeRises = 0;
  logic prevFwd = 1'b0, prevFreeO = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(gateFwd === expFwd[0], {curReq, " gateFwd"}, int'(gateFwd), expFwd);
    chk(gateFree === expFree[0], {curReq, " gateFree"}, int'(gateFree), expFree);
    // R3 exclusivity
    chk(!(gateFwd && gateFree), "R3", int'(gateFwd && gateFree), 0);
    if (gateFwd) fwdRun++;
    else if (prevFwd) begin lastFwdW = fwdRun; fwdRun = 0; end
    if (gateFree) freeRun++;
    else if (prevFreeO) begin lastFreeW = freeRun; freeRun = 0; end
    if (gateFwd && !prevFwd) fwdRises++;
    if (gateFree && !prevFreeO) freeRises++;
    prevFwd = gateFwd; prevFreeO = gateFree;
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) begin ck = v; step(); end
  endtask

  task automatic periods(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin hold(1'b1, hi); hold(1'b0, lo); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (4) step();
    chk(gateFwd == 1'b0 && gateFree == 1'b0, "R1 reset", int'({gateFwd, gateFree}), 0);
    rstN = 1'b1;
    hold(1'b0, 10);

    // R2: no output until three qualified edges
    curReq = "R2";
    fwdRises = 0; freeRises = 0;
    hold(1'b1, 20); hold(1'b0, 30);
    chk(fwdRises + freeRises == 0, "R2 first period", fwdRises + freeRises, 0);

    // R5/R6 steady state, select 0
    curReq = "R5";
    periods(20, 30, 4);
    chk(lastFwdW == 17, "R5 fwd width", lastFwdW, 17);
    chk(lastFreeW == 28, "R6 free width sel0", lastFreeW, 28);

    curReq = "R6";
    sel = 2'd1; periods(20, 30, 3);
    chk(lastFreeW == 27, "R6 free width sel1", lastFreeW, 27);
    sel = 2'd2; periods(20, 30, 3);
    chk(lastFreeW == 26, "R6 free width sel2", lastFreeW, 26);
    sel = 2'd3; periods(20, 30, 3);
    chk(lastFreeW == 26, "R6 free width sel3", lastFreeW, 26);
    sel = 2'd0; periods(20, 30, 2);

    // R4 glitches inside both phases
    curReq = "R4";
    for (int i = 0; i < 3; i++) begin
      hold(1'b1, 8); hold(1'b0, 2); hold(1'b1, 10);
      hold(1'b0, 10); hold(1'b1, 2); hold(1'b0, 18);
    end
    chk(lastFwdW == 17, "R4 fwd width with glitch", lastFwdW, 17);
    chk(lastFreeW == 28, "R4 free width with glitch", lastFreeW, 28);

    // R8 inhibit with minimum conduction
    curReq = "R8";
    inh = 1'b1; periods(20, 30, 3);
    chk(lastFreeW == MIN_ON2, "R8 min conduction", lastFreeW, MIN_ON2);
    inh = 1'b0;
    hold(1'b1, 20); hold(1'b0, 12); inh = 1'b1; hold(1'b0, 18); inh = 1'b0;
    periods(20, 30, 2);

    // R11 early edge truncation
    curReq = "R11";
    hold(1'b1, 10); hold(1'b0, 30);
    chk(lastFwdW == 8, "R11 truncated fwd", lastFwdW, 8);
    periods(10, 30, 2);
    chk(lastFwdW == 7, "R11 next prediction", lastFwdW, 7);

    // R10 low-duty variant keeps switching at 10%
    curReq = "R10";
    lowd = 1'b1; periods(5, 45, 4);
    chk(lastFwdW == 2, "R10 fwd at low duty", lastFwdW, 2);

    // R7 skip when phase too short (4 ticks is the boundary)
    curReq = "R7";
    periods(3, 30, 3);
    fwdRises = 0; periods(3, 30, 3);
    chk(fwdRises == 0, "R7 fwd skipped", fwdRises, 0);
    periods(4, 30, 3);
    chk(lastFwdW == 1, "R7 fwd boundary width", lastFwdW, 1);
    sel = 2'd2; periods(30, 4, 3);
    freeRises = 0; periods(30, 4, 3);
    chk(freeRises == 0, "R7 free skipped", freeRises, 0);
    sel = 2'd0;

    // R9 shutdown with hysteresis
    curReq = "R9";
    lowd = 1'b0; periods(5, 45, 3);
    fwdRises = 0; freeRises = 0; periods(5, 45, 3);
    chk(fwdRises + freeRises == 0, "R9 shutdown at 10%", fwdRises + freeRises, 0);
    periods(7, 43, 3);
    chk(fwdRises + freeRises == 0, "R9 hold off at 14%", fwdRises + freeRises, 0);
    periods(10, 40, 3);
    chk(fwdRises > 0, "R9 restart at 20%", fwdRises, 1);
    chk(lastFwdW == 7, "R9 width after restart", lastFwdW, 7);
    fwdRises = 0; periods(7, 43, 3);
    chk(fwdRises > 0, "R9 keep running at 14%", fwdRises, 1);

    // R1 undervoltage drop and re-measurement
    curReq = "R1";
    periods(20, 30, 3);
    hold(1'b1, 8); uv = 1'b0; step();
    chk(gateFwd == 1'b0 && gateFree == 1'b0, "R1 uv low", int'({gateFwd, gateFree}), 0);
    hold(1'b1, 12); hold(1'b0, 30); uv = 1'b1;
    curReq = "R2";
    fwdRises = 0; freeRises = 0;
    hold(1'b1, 20); hold(1'b0, 30);
    chk(fwdRises + freeRises == 0, "R2 after uv restore", fwdRises + freeRises, 0);
    periods(20, 30, 3);
    chk(lastFwdW == 17, "R1 resumed width", lastFwdW, 17);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule